// File: doc/BRIEF.md
# Programmable Dead-Time Generator

This block turns one PWM command per channel into a pair of complementary gate enables for a synchronous buck stage. One enable drives the high-side switch and the other drives the low-side switch. Each time the command changes level, the block opens a blanking gap during which both enables are low. The gap before the high-side turn-on (rise gap) and the gap before the low-side turn-on (fall gap) are programmed separately for each channel. They are counted in cycles of a shared time-base clock. That clock runs at 256 times the switching frequency, so one count is 1/256 of a switching period.

A global mode bit selects between the programmed gaps and a fixed built-in non-overlap interval of two time-base cycles. Four identical channels run from the same clock. A one-cycle write port loads the mode bit and the eight per-channel gap registers. A channel copies its gap settings and the mode bit when it starts a high-side turn-on sequence. A write therefore never changes a gap that is already under way or the gaps of the pulse in progress. A per-channel enable pulls both gate enables low at once.

Top module: `gate_deadtime_quad`

## Requirements
- R1: While reset is held, every gate enable is low and the control bit reads as fixed mode (0). After release, an enabled channel whose PWM input is low asserts its low-side enable on the first clock edge.
- R2: The high-side and low-side enables of a channel are never high in the same sampled cycle.
- R3: In programmable mode, a PWM rise sampled at clock edge k drops the low-side enable at edge k+1. The high-side enable then rises exactly D cycles later, where D is that channel's 8-bit rise register.
- R4: In programmable mode, a PWM fall sampled at edge k drops the high-side enable at edge k+1. The low-side enable then rises exactly F cycles later, where F is that channel's 8-bit fall register.
- R5: With the control bit at 0, both gaps are exactly 2 cycles whatever the gap registers hold.
- R6: A gap register value of 0 makes one enable fall and the other rise on the same clock edge.
- R7: If the PWM input returns low while a rise gap is still counting, the high-side enable stays low for that pulse. The low-side enable returns on the second edge after the input falls.
- R8: A low channel enable forces both gate enables of that channel low in the same cycle, without waiting for a clock edge. When the enable returns with the PWM input low, the low-side enable comes back on the next edge.
- R9: A write is taken on a clock edge with the write strobe high. Address 0 bit 0 is the control bit. Address 2c+1 is the rise register of channel c and address 2c+2 is its fall register.
- R10: Gap settings and the mode bit are copied when a channel starts a rise sequence. Writes made while the high-side enable is on do not change the fall gap that follows; they apply from the next pulse.
- R11: Channels are independent: activity on one channel leaves the enables of idle channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock, 256 times the switching frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | NCH | PWM command, one bit per channel |
| ch_en | input | NCH | Channel enable, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DW | Register write data |
| hs_out | output | NCH | High-side gate enable per channel |
| ls_out | output | NCH | Low-side gate enable per channel |

## Verification
A corrupted gap counter or state register shows up directly at the edges of the two enables. The gap measured between one enable falling and the other rising then differs from the programmed count within that same switching transition. A stale copy of the settings appears as a wrong fall gap on the pulse in which a write was made. A stuck sequence state appears within two cycles as a missing low-side return or as a high-side pulse that should have been suppressed. Each gap is therefore measured edge to edge on every channel, in both modes and at the values 0, 1 and 255.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_LOW  = 3'd1,
        ST_RGAP = 3'd2,
        ST_HIGH = 3'd3,
        ST_FGAP = 3'd4
    } gdt_state_e;
endpackage

// File: rtl/gdt_regs.sv
module gdt_regs #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output logic                    prog_mode,
    output logic [NCH-1:0][DW-1:0]  rise_dly,
    output logic [NCH-1:0][DW-1:0]  fall_dly
);
    typedef struct packed {
        logic                   mode;
        logic [NCH-1:0][DW-1:0] rise;
        logic [NCH-1:0][DW-1:0] fall;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == '0) regs_d.mode = wr_data[0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == AW'(2 * c + 1)) regs_d.rise[c] = wr_data;
                if (wr_addr == AW'(2 * c + 2)) regs_d.fall[c] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign prog_mode = regs_q.mode;
    assign rise_dly  = regs_q.rise;
    assign fall_dly  = regs_q.fall;

    assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (prog_mode == $past(wr_data[0])));
endmodule

// File: rtl/gdt_channel.sv
module gdt_channel
    import gdt_pkg::*;
#(
    parameter int DW        = 8,
    parameter int FIXED_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pwm,
    input  logic          prog_mode,
    input  logic [DW-1:0] rise_dly,
    input  logic [DW-1:0] fall_dly,
    output logic          hs,
    output logic          ls
);
    localparam logic [DW-1:0] FIX = DW'(FIXED_GAP);

    typedef struct packed {
        gdt_state_e    st;
        logic [DW-1:0] cnt;
        logic [DW-1:0] fall_lat;
        logic          mode_lat;
        logic          pwm;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [DW-1:0] eff_rise;
    logic [DW-1:0] eff_fall;
    logic hs_i, ls_i;

    assign eff_rise = prog_mode ? rise_dly : FIX;
    assign eff_fall = prog_mode ? fall_dly : FIX;

    always_comb begin
        ch_d     = ch_q;
        ch_d.pwm = pwm;
        unique case (ch_q.st)
            ST_OFF, ST_LOW: begin
                if (ch_q.pwm) begin
                    ch_d.fall_lat = eff_fall;
                    ch_d.mode_lat = prog_mode;
                    if (eff_rise == '0) begin
                        ch_d.st = ST_HIGH;
                    end else begin
                        ch_d.st  = ST_RGAP;
                        ch_d.cnt = eff_rise - 1'b1;
                    end
                end else begin
                    ch_d.st = ST_LOW;
                end
            end
            ST_RGAP: begin
                if (!ch_q.pwm)            ch_d.st  = ST_LOW;
                else if (ch_q.cnt == '0)  ch_d.st  = ST_HIGH;
                else                      ch_d.cnt = ch_q.cnt - 1'b1;
            end
            ST_HIGH: begin
                if (!ch_q.pwm) begin
                    if (ch_q.fall_lat == '0) begin
                        ch_d.st = ST_LOW;
                    end else begin
                        ch_d.st  = ST_FGAP;
                        ch_d.cnt = ch_q.fall_lat - 1'b1;
                    end
                end
            end
            ST_FGAP: begin
                if (ch_q.cnt == '0) ch_d.st  = ST_LOW;
                else                ch_d.cnt = ch_q.cnt - 1'b1;
            end
            default: ch_d.st = ST_OFF;
        endcase
        if (!en) ch_d.st = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q    <= '0;
            ch_q.st <= ST_OFF;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign hs_i = (ch_q.st == ST_HIGH);
    assign ls_i = (ch_q.st == ST_LOW);
    assign hs   = en & hs_i;
    assign ls   = en & ls_i;

    // R5: in fixed mode the low side has been off for two cycles before high side rises
    assert_fixed_rise_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_i) && !ch_q.mode_lat) |-> ($past(!ls_i, 1) && $past(!ls_i, 2)));

    assert_runt_no_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.st == ST_RGAP && !ch_q.pwm && en) |=> (ls_i && !hs_i));

    assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_i && !ls_i));

    assert_fall_latch_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_i && $past(hs_i)) |-> $stable(ch_q.fall_lat));
endmodule

// File: rtl/gate_deadtime_quad.sv
module gate_deadtime_quad #(
    parameter int NCH       = 4,
    parameter int DW        = 8,
    parameter int FIXED_GAP = 2,
    parameter int ADDR_W    = $clog2(2 * NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pwm_in,
    input  logic [NCH-1:0]    ch_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH-1:0]    hs_out,
    output logic [NCH-1:0]    ls_out
);
    logic                   prog_mode;
    logic [NCH-1:0][DW-1:0] rise_dly;
    logic [NCH-1:0][DW-1:0] fall_dly;

    gdt_regs #(.NCH(NCH), .DW(DW), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prog_mode (prog_mode),
        .rise_dly  (rise_dly),
        .fall_dly  (fall_dly)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gdt_channel #(.DW(DW), .FIXED_GAP(FIXED_GAP)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[i]),
            .pwm       (pwm_in[i]),
            .prog_mode (prog_mode),
            .rise_dly  (rise_dly[i]),
            .fall_dly  (fall_dly[i]),
            .hs        (hs_out[i]),
            .ls        (ls_out[i])
        );
    end
endmodule

// File: tb/gate_deadtime_quad_test.sv
module gate_deadtime_quad_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm_in = '0;
    logic [NCH-1:0] ch_en = '1;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] hs_out, ls_out;

    int n_run  = 0;
    int n_fail = 0;
    int n_ovl  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gate_deadtime_quad uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .ch_en(ch_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hs_out(hs_out), .ls_out(ls_out)
    );

    // fields: ch[34:33] mode[32] rise[31:24] fall[23:16] exp_rise_gap[15:8] exp_fall_gap[7:0]
    localparam logic [34:0] VEC [6] = '{
        {2'd0, 1'b1, 8'd5,   8'd9,  8'd5,   8'd9},
        {2'd1, 1'b1, 8'd0,   8'd0,  8'd0,   8'd0},
        {2'd2, 1'b0, 8'd40,  8'd3,  8'd2,   8'd2},
        {2'd3, 1'b1, 8'd255, 8'd1,  8'd255, 8'd1},
        {2'd1, 1'b1, 8'd1,   8'd17, 8'd1,   8'd17},
        {2'd2, 1'b1, 8'd12,  8'd0,  8'd12,  8'd0}
    };

    always @(negedge clk) if (rst_n && ((hs_out & ls_out) != '0)) n_ovl++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rise(input int ch, output int lat, output int gap);
        int hsr;
        lat = -1; hsr = -1;
        pwm_in[ch] = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (lat < 0 && !ls_out[ch]) lat = i;
            if (hs_out[ch]) begin hsr = i; break; end
        end
        gap = (lat < 0 || hsr < 0) ? -1 : hsr - lat;
    endtask

    task automatic do_fall(input int ch, output int lat, output int gap);
        int lsr;
        lat = -1; lsr = -1;
        pwm_in[ch] = 1'b0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (lat < 0 && !hs_out[ch]) lat = i;
            if (ls_out[ch]) begin lsr = i; break; end
        end
        gap = (lat < 0 || lsr < 0) ? -1 : lsr - lat;
    endtask

    task automatic finish_run();
        chk(n_ovl == 0, "R2 overlap cycles", n_ovl, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, gap;
        bit hs_seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(hs_out == '0 && ls_out == '0, "R1 outputs in reset", int'({hs_out, ls_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ls_out == '1 && hs_out == '0, "R1 low side after release", int'(ls_out), 15);
        // R1/R5: control resets to fixed mode, so zero registers still give 2-cycle gaps
        do_rise(0, lat, gap);
        chk(lat == 2 && gap == 2, "R1 fixed mode after reset, rise gap", gap, 2);
        repeat (3) @(negedge clk);
        do_fall(0, lat, gap);
        chk(lat == 2 && gap == 2, "R1 fixed mode after reset, fall gap", gap, 2);
        repeat (2) @(negedge clk);

        // table walk: R3 R4 R5 R6 R9 R11
        for (int v = 0; v < 6; v++) begin
            int ch, er, ef;
            ch = int'(VEC[v][34:33]);
            er = int'(VEC[v][15:8]);
            ef = int'(VEC[v][7:0]);
            wr(2 * ch + 1, int'(VEC[v][31:24]));
            wr(2 * ch + 2, int'(VEC[v][23:16]));
            wr(0, int'(VEC[v][32]));
            do_rise(ch, lat, gap);
            chk(lat == 2, $sformatf("R3 low-side drop latency vec%0d", v), lat, 2);
            chk(gap == er, $sformatf("R3/R5/R6 rise gap vec%0d", v), gap, er);
            repeat (4) @(negedge clk);
            do_fall(ch, lat, gap);
            chk(lat == 2, $sformatf("R4 high-side drop latency vec%0d", v), lat, 2);
            chk(gap == ef, $sformatf("R4/R5/R6 fall gap vec%0d", v), gap, ef);
            for (int o = 0; o < NCH; o++)
                if (o != ch)
                    chk(ls_out[o] && !hs_out[o], $sformatf("R11 idle ch%0d during vec%0d", o, v),
                        int'({hs_out[o], ls_out[o]}), 1);
            repeat (2) @(negedge clk);
        end

        // R10: writes during the high phase do not alter the pending fall gap
        wr(1, 4); wr(2, 6); wr(0, 1);
        do_rise(0, lat, gap);
        chk(gap == 4, "R10 rise gap before rewrite", gap, 4);
        wr(1, 30); wr(2, 30);
        do_fall(0, lat, gap);
        chk(gap == 6, "R10 fall gap keeps copied value", gap, 6);
        repeat (2) @(negedge clk);
        do_rise(0, lat, gap);
        chk(gap == 30, "R10 new rise gap on next pulse", gap, 30);
        repeat (2) @(negedge clk);
        do_fall(0, lat, gap);
        chk(gap == 30, "R10 new fall gap on next pulse", gap, 30);
        repeat (2) @(negedge clk);

        // R7: pulse shorter than the rise gap
        wr(3, 10);
        hs_seen = 1'b0;
        pwm_in[1] = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (hs_out[1]) hs_seen = 1'b1;
        end
        pwm_in[1] = 1'b0;
        @(negedge clk);
        if (hs_out[1]) hs_seen = 1'b1;
        chk(!ls_out[1], "R7 low side still off one edge after fall", int'(ls_out[1]), 0);
        @(negedge clk);
        if (hs_out[1]) hs_seen = 1'b1;
        chk(ls_out[1], "R7 low side back on second edge", int'(ls_out[1]), 1);
        repeat (5) begin
            @(negedge clk);
            if (hs_out[1]) hs_seen = 1'b1;
        end
        chk(!hs_seen, "R7 high side suppressed for short pulse", int'(hs_seen), 0);

        // R8: disable from low-side-on state
        ch_en[2] = 1'b0;
        #1;
        chk(!ls_out[2] && !hs_out[2], "R8 immediate off from low state", int'({hs_out[2], ls_out[2]}), 0);
        pwm_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk(!hs_out[2] && !ls_out[2], "R8 stays off while disabled", int'({hs_out[2], ls_out[2]}), 0);
        pwm_in[2] = 1'b0;
        @(negedge clk);
        ch_en[2] = 1'b1;
        @(negedge clk);
        chk(ls_out[2], "R8 low side on next edge after enable", int'(ls_out[2]), 1);

        // R8: disable with the high side on
        wr(7, 3); wr(8, 3);
        do_rise(3, lat, gap);
        chk(hs_out[3] && gap == 3, "R8 setup high side on", gap, 3);
        ch_en[3] = 1'b0;
        #1;
        chk(!hs_out[3] && !ls_out[3], "R8 immediate off from high state", int'({hs_out[3], ls_out[3]}), 0);
        pwm_in[3] = 1'b0;
        @(negedge clk);
        ch_en[3] = 1'b1;
        @(negedge clk);
        chk(ls_out[3] && !hs_out[3], "R8 recovery to low side", int'({hs_out[3], ls_out[3]}), 1);

        // R9: control bit back to 0 restores fixed gaps despite large registers
        wr(0, 0);
        do_rise(0, lat, gap);
        chk(gap == 2, "R9 control clear selects fixed rise gap", gap, 2);
        repeat (2) @(negedge clk);
        do_fall(0, lat, gap);
        chk(gap == 2, "R9 control clear selects fixed fall gap", gap, 2);

        finish_run();
    end
endmodule